// File: doc/BRIEF.md
# Serial Link Training Controller

This block sits on the transmitter side of a multi-lane video serial link. It decides when the transmitter powers down, when it sends the clock-recovery training pattern, and when it passes user pixel and control data to the serializer. Two sideband status lines come back from the receiver. Both are active low, open drain and pulled up. The first says a receiver is present and active. The second says the receiver's clock-data-recovery loop has locked.

Each sideband line goes through a synchronizer chain. It then goes through a glitch filter that accepts a new level only after that level has been held for `HOLD_CYCLES` consecutive clocks. A three-state machine uses the filtered levels:
- It stays in power-down while the connection line is high.
- It moves to training as soon as the connection line is low.
- It moves to normal mode once the lock line is also low.

A strap input covers boards where the connection wire is not fitted. When the strap is set, the connection line is read as permanently low. All three outputs come straight from the state register.

Top module: `link_train_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving reset, `pwr_down`=1, `sel_payload`=0 and `link_up`=0.
- R2: When the filtered connection line is high, the controller enters power-down on the next cycle from any state. In power-down `pwr_down`=1 and `sel_payload`=0.
- R3: In power-down with the filtered connection line low, the next cycle is training: `pwr_down`=0, `sel_payload`=0 (training pattern), `link_up`=0.
- R4: In training, while the filtered lock line stays high and the connection line stays low, the controller remains in training.
- R5: In training with the filtered lock line low, the next cycle is normal mode: `sel_payload`=1 (payload) and `link_up`=1.
- R6: The lock line has no effect while the connection line is high. The controller stays in power-down whatever the lock line does.
- R7: With `conn_absent_strap`=1, the connection line is read as low regardless of the `conn_n_pin` level.
- R8: Both synchronizers and filters reset to the high (idle) level. A receiver that is absent or unpowered therefore reads as not connected and not locked.
- R9: A change on either sideband line is accepted only after the new level has been held for `HOLD_CYCLES` consecutive synchronized cycles. A pulse one cycle shorter has no effect.
- R10: A level change held long enough at a pin reaches the outputs exactly `SYNC_STAGES + HOLD_CYCLES + 1` clock edges after it was applied.
- R11: In normal mode, if the filtered lock line returns high, the controller goes back to training on the next cycle. `link_up` and `sel_payload` drop to 0 and `pwr_down` stays 0.
- R12: `sel_payload` and `link_up` are 1 only in normal mode. They are registered outputs and are never 1 together with `pwr_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_n_pin | input | 1 | Active-low connection status from the receiver, asynchronous |
| lock_n_pin | input | 1 | Active-low clock-recovery lock status from the receiver, asynchronous |
| conn_absent_strap | input | 1 | When 1, the connection line is treated as permanently low |
| pwr_down | output | 1 | Request to power down the transmitter |
| sel_payload | output | 1 | Data-path select: 1 = user data, 0 = training pattern |
| link_up | output | 1 | Link in normal mode |

## Verification
The bench builds the block with `HOLD_CYCLES`=4 and `SYNC_STAGES`=2. This gives a pin-to-output latency of seven edges. The filter boundary is then short enough to probe exactly: a three-cycle pulse is rejected and a four-cycle pulse is accepted. With the same settings, the latency can be checked one edge early and at the expected edge.

The small filter window also keeps each random hold short. Several hundred random level pairs on both sideband lines, mixed with sub-threshold glitches, therefore fit in a short run.

The directed cases cover:
- falling out of normal mode on loss of lock;
- dropping the connection while locked;
- the two-step entry into normal mode when lock is already low at connection time;
- the strap overriding a high connection pin.

// File: rtl/link_train_ctrl.sv
module link_train_ctrl #(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_n_pin,
  input  logic lock_n_pin,
  input  logic conn_absent_strap,
  output logic pwr_down,
  output logic sel_payload,
  output logic link_up
);

  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [1:0] {ST_PDN, ST_TRAIN, ST_NORMAL} st_t;

  logic [SYNC_STAGES-1:0] conn_sh, lock_sh;
  logic [1:0]             raw, flt;
  logic [CW-1:0]          cnt [2];
  st_t                    st, nxt;
  logic                   conn_f, lock_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_sh <= '1;
      lock_sh <= '1;
    end else begin
      conn_sh <= {conn_sh[SYNC_STAGES-2:0], conn_n_pin};
      lock_sh <= {lock_sh[SYNC_STAGES-2:0], lock_n_pin};
    end
  end

  assign raw[0] = conn_absent_strap ? 1'b0 : conn_sh[SYNC_STAGES-1];
  assign raw[1] = lock_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt <= 2'b11;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (raw[i] == flt[i]) begin
          cnt[i] <= '0;
        end else if (cnt[i] == CNT_LAST) begin
          flt[i] <= raw[i];
          cnt[i] <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  assign conn_f = flt[0];
  assign lock_f = flt[1];

  always_comb begin
    nxt = st;
    if (conn_f) nxt = ST_PDN;
    else begin
      case (st)
        ST_PDN:    nxt = ST_TRAIN;
        ST_TRAIN:  if (!lock_f) nxt = ST_NORMAL;
        ST_NORMAL: if (lock_f)  nxt = ST_TRAIN;
        default:   nxt = ST_PDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_PDN;
    else        st <= nxt;
  end

  assign pwr_down    = (st == ST_PDN);
  assign sel_payload = (st == ST_NORMAL);
  assign link_up     = (st == ST_NORMAL);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> pwr_down && !sel_payload && !link_up);

  assert_conn_high_pdn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_f |=> pwr_down && !sel_payload);

  assert_leave_pdn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDN && !conn_f) |=> !pwr_down && !sel_payload && !link_up);

  assert_train_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRAIN && !conn_f && lock_f) |=> !pwr_down && !sel_payload);

  assert_to_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRAIN && !conn_f && !lock_f) |=> link_up && sel_payload);

  assert_lock_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDN && conn_f) |=> pwr_down);

  assert_conn_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] == flt[0]) |=> $stable(flt[0]));

  assert_lock_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] == flt[1]) |=> $stable(flt[1]));

  assert_lock_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORMAL && !conn_f && lock_f) |=> !link_up && !sel_payload && !pwr_down);

  assert_payload_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_payload && pwr_down));

  assert_payload_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_payload) |-> $past(!lock_f && !conn_f));

endmodule

// File: tb/link_train_ctrl_test.sv
module link_train_ctrl_test;

  localparam int HOLD = 4;
  localparam int SYNC = 2;
  localparam int LAT  = HOLD + SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conn_n = 1'b1, lock_n = 1'b1, strap = 1'b0;
  logic pwr_down, sel_payload, link_up;
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  link_train_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .conn_n_pin(conn_n), .lock_n_pin(lock_n),
    .conn_absent_strap(strap), .pwr_down(pwr_down),
    .sel_payload(sel_payload), .link_up(link_up));

  // mode: 0 power-down, 1 training, 2 normal
  function automatic logic [2:0] mode_outs(int mode);
    case (mode)
      0: return 3'b100;
      1: return 3'b000;
      default: return 3'b011;
    endcase
  endfunction

  function automatic int settled_mode(logic c_n, logic l_n, logic s);
    if (c_n && !s) return 0;
    if (!l_n) return 2;
    return 1;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int mode);
    logic [2:0] act, exp;
    act = {pwr_down, sel_payload, link_up};
    exp = mode_outs(mode);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pwr_down,sel_payload,link_up} act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int m;
    step(3);
    chk("R1 in reset", 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset", 0);
    step(20);
    chk("R8 idle-high pins stay powered down", 0);

    // connection arrives: latency boundary
    conn_n = 1'b0;
    step(LAT - 1);
    chk("R10 one edge early", 0);
    step(1);
    chk("R3 R10 training on time", 1);
    step(20);
    chk("R4 stays training while unlocked", 1);

    // lock arrives
    lock_n = 1'b0;
    step(LAT - 1);
    chk("R10 lock one edge early", 1);
    step(1);
    chk("R5 R12 normal mode", 2);

    // glitch on lock one cycle short
    lock_n = 1'b1; step(HOLD - 1); lock_n = 1'b0;
    step(20);
    chk("R9 short lock pulse ignored", 2);

    // pulse held exactly HOLD cycles is accepted
    lock_n = 1'b1; step(HOLD); lock_n = 1'b0;
    step(SYNC + HOLD);
    chk("R9 R11 full-length pulse drops to training", 1);
    step(20);
    chk("R5 relock", 2);

    // lock loss from normal
    lock_n = 1'b1;
    step(LAT - 1);
    chk("R11 still up one edge early", 2);
    step(1);
    chk("R11 link_up drops to training", 1);
    lock_n = 1'b0;
    step(20);
    chk("R5 relock again", 2);

    // connection loss while locked
    conn_n = 1'b1;
    step(LAT);
    chk("R2 connection loss forces power-down", 0);
    for (int k = 0; k < 6; k++) begin
      lock_n = ~lock_n;
      step(12);
      chk("R6 lock ignored while disconnected", 0);
    end
    lock_n = 1'b0;
    step(20);

    // reconnect with lock already low: training first, then normal
    conn_n = 1'b0;
    step(LAT);
    chk("R3 training before normal", 1);
    step(1);
    chk("R5 normal one cycle later", 2);

    // short connection glitch
    conn_n = 1'b1; step(HOLD - 1); conn_n = 1'b0;
    step(20);
    chk("R9 short connection pulse ignored", 2);

    // strap overrides a high connection pin
    conn_n = 1'b1; lock_n = 1'b1;
    step(30);
    chk("R2 disconnected", 0);
    strap = 1'b1;
    step(30);
    chk("R7 strap reads connection low", 1);
    lock_n = 1'b0;
    step(30);
    chk("R7 strap allows normal mode", 2);
    strap = 1'b0;
    step(30);
    chk("R2 strap removed", 0);

    // reset from the middle of a run
    conn_n = 1'b0;
    step(30);
    chk("R5 before reset", 2);
    rst_n = 1'b0;
    step(2);
    chk("R1 reset mid-run", 0);
    rst_n = 1'b1;

    // random phase
    void'($urandom(32'd20240611));
    step(30);
    m = settled_mode(conn_n, lock_n, strap);
    chk("R12 settle after reset", m);
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(1, 0) == 1) begin
        int g = $urandom_range(HOLD - 1, 1);
        if ($urandom_range(1, 0) == 1) begin
          conn_n = ~conn_n; step(g); conn_n = ~conn_n;
        end else begin
          lock_n = ~lock_n; step(g); lock_n = ~lock_n;
        end
        step(LAT + 3);
        chk("R9 random glitch ignored", m);
      end else begin
        conn_n = 1'($urandom_range(1, 0));
        lock_n = 1'($urandom_range(1, 0));
        step($urandom_range(30, LAT + 2));
        m = settled_mode(conn_n, lock_n, strap);
        chk("R2 R4 R5 R6 random settled mode", m);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule